// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block runs the string of machine cycles that follows the acceptance of an interrupt in a small 8-bit processor. When a maskable request is pending and enabled, it asks the bus cycle engine for an acknowledge cycle and takes the opcode the interrupting device returns. A restart opcode carries its vector in three of its bits. A call opcode makes the block collect a 16-bit target through two more acknowledge cycles. Either form then pushes the program counter onto the stack with two memory writes and hands the core a new program counter and stack pointer.

A non-maskable trap skips the bus read. It spends one idle cycle and pushes the program counter in the same way, then jumps to a fixed vector. Each bus cycle is requested through a level request and a one-cycle `done_i` completion. The actual pin timing is left to the bus cycle engine. Starting any sequence clears the maskable enable. The enable stays cleared until the core pulses `ei_i`.

Top module: `iack_seq`

## Requirements
- R1: After reset `req_o`, `busy_o`, `int_en_o`, `pc_load_o`, `sp_load_o` and `err_o` are all 0.
- R2: `intr_i` starts a sequence only while `int_en_o` is 1 and the block is idle. A pulse on `ei_i` sets `int_en_o`. Accepting any sequence (maskable or trap) clears `int_en_o`, and the clear wins over a simultaneous `ei_i`.
- R3: An acknowledge request has `req_status_o` = 3'b111 ({io_m, s1, s0}) and `req_addr_o` equal to the program counter captured at acceptance.
- R4: A returned opcode with bits [7:6] = 2'b11 and bits [2:0] = 3'b111 is a restart. No further acknowledge follows, and the new program counter is bits [5:3] times 8.
- R5: A returned opcode of 8'hCD is a call. Two more acknowledge requests follow. The first returns the low byte of the target and the second returns the high byte.
- R6: The push is two memory-write requests with `req_status_o` = 3'b001. The first writes the high program counter byte at SP−1 and the second writes the low byte at SP−2. Addresses wrap modulo 2^16.
- R7: After the second write completes, `pc_load_o` and `sp_load_o` are 1 for exactly one cycle. During that cycle `new_pc_o` is the vector and `new_sp_o` is the captured SP − 2.
- R8: A trap request makes one idle request (`req_status_o` = 3'b000, address = captured PC), then the push, then loads 16'h0024. This happens whatever the value of `int_en_o`.
- R9: When `trap_i` and an enabled `intr_i` arrive in the same cycle, the trap sequence runs and no acknowledge is issued.
- R10: Any other returned opcode produces a one-cycle `err_o` pulse with no write request and no load. The block returns to idle.
- R11: Once raised, `req_o`, `req_status_o`, `req_addr_o` and `req_wdata_o` hold steady until `done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intr_i | input | 1 | Maskable interrupt request |
| trap_i | input | 1 | Non-maskable trap request |
| ei_i | input | 1 | Core pulse that sets the maskable enable |
| pc_i | input | 16 | Current program counter, captured at acceptance |
| sp_i | input | 16 | Current stack pointer, captured at acceptance |
| req_o | output | 1 | Bus cycle request |
| req_status_o | output | 3 | Cycle status {io_m, s1, s0} |
| req_addr_o | output | 16 | Cycle address |
| req_wdata_o | output | 8 | Write data for memory-write requests |
| done_i | input | 1 | One-cycle completion of the current request |
| rdata_i | input | 8 | Byte read during an acknowledge, valid with `done_i` |
| busy_o | output | 1 | A sequence is in progress |
| int_en_o | output | 1 | Maskable interrupt enable |
| pc_load_o | output | 1 | Load strobe for the new program counter |
| new_pc_o | output | 16 | New program counter |
| sp_load_o | output | 1 | Load strobe for the new stack pointer |
| new_sp_o | output | 16 | New stack pointer |
| err_o | output | 1 | Unsupported acknowledge opcode |

## Verification
The bench targets the boundary restarts 0 and 7. A wrong vector shift or a wrong bit field would load an address off by a multiple of 8. It also pushes with SP = 1, so the push addresses and the new SP must wrap below zero; an adder narrower than the address would corrupt the write at 16'hFFFF. A call checks the byte order of the target, which a swap would reverse. A simultaneous trap and enabled interrupt checks priority: a design that favours the interrupt would emit a 3'b111 request first. An unsupported opcode must end with no write and no load. The request queue would flag a stray push, and the result wait would catch a missing error pulse.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {OP_RST, OP_CALL, OP_BAD} op_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_TRAP, S_ACK, S_ACK_LO, S_ACK_HI, S_PUSH_HI, S_PUSH_LO, S_LOAD
  } seq_state_e;

  // {io_m, s1, s0}
  localparam logic [2:0] ST_ACK  = 3'b111;
  localparam logic [2:0] ST_MWR  = 3'b001;
  localparam logic [2:0] ST_IDLE = 3'b000;
endpackage

// File: rtl/iack_decode.sv
module iack_decode
  import iack_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 16,
  parameter logic [7:0]  CALL_OP = 8'hCD
) (
  input  logic [DW-1:0] op_i,
  output op_kind_e      kind_o,
  output logic [AW-1:0] rst_vec_o
);
  localparam int unsigned VPAD = AW - 6;

  logic is_rst;
  assign is_rst = (op_i[7:6] == 2'b11) && (op_i[2:0] == 3'b111);

  always_comb begin
    if (is_rst)                kind_o = OP_RST;
    else if (op_i == CALL_OP)  kind_o = OP_CALL;
    else                       kind_o = OP_BAD;
  end

  // restart n -> n*8
  assign rst_vec_o = {{VPAD{1'b0}}, op_i[5:3], 3'b000};
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter logic [15:0] TRAP_VEC = 16'h0024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          intr_i,
  input  logic          trap_i,
  input  logic          ei_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  input  op_kind_e      kind_i,
  input  logic [AW-1:0] rst_vec_i,
  output logic          req_o,
  output logic [2:0]    req_status_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic          busy_o,
  output logic          int_en_o,
  output logic          pc_load_o,
  output logic [AW-1:0] new_pc_o,
  output logic          sp_load_o,
  output logic [AW-1:0] new_sp_o,
  output logic          err_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, sp_q, vec_q;
  logic          int_en_q, err_q;
  logic          accept, take_trap;
  logic [AW-1:0] sp_m1, sp_m2;

  assign take_trap = (state_q == S_IDLE) && trap_i;
  assign accept    = (state_q == S_IDLE) && (trap_i || (intr_i && int_en_q));
  assign sp_m1     = sp_q - ONE;
  assign sp_m2     = sp_q - TWO;

  always_comb begin
    state_d      = state_q;
    req_o        = 1'b0;
    req_status_o = ST_IDLE;
    req_addr_o   = pc_q;
    req_wdata_o  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (take_trap)   state_d = S_TRAP;
        else if (accept) state_d = S_ACK;
      end
      S_TRAP: begin
        req_o = 1'b1;
        if (done_i) state_d = S_PUSH_HI;
      end
      S_ACK: begin
        req_o        = 1'b1;
        req_status_o = ST_ACK;
        if (done_i) begin
          unique case (kind_i)
            OP_RST:  state_d = S_PUSH_HI;
            OP_CALL: state_d = S_ACK_LO;
            default: state_d = S_IDLE;
          endcase
        end
      end
      S_ACK_LO: begin
        req_o        = 1'b1;
        req_status_o = ST_ACK;
        if (done_i) state_d = S_ACK_HI;
      end
      S_ACK_HI: begin
        req_o        = 1'b1;
        req_status_o = ST_ACK;
        if (done_i) state_d = S_PUSH_HI;
      end
      S_PUSH_HI: begin
        req_o        = 1'b1;
        req_status_o = ST_MWR;
        req_addr_o   = sp_m1;
        req_wdata_o  = pc_q[AW-1 -: DW];
        if (done_i) state_d = S_PUSH_LO;
      end
      S_PUSH_LO: begin
        req_o        = 1'b1;
        req_status_o = ST_MWR;
        req_addr_o   = sp_m2;
        req_wdata_o  = pc_q[DW-1:0];
        if (done_i) state_d = S_LOAD;
      end
      S_LOAD:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pc_q     <= '0;
      sp_q     <= '0;
      vec_q    <= '0;
      int_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == S_ACK) && done_i && (kind_i == OP_BAD);
      if (accept)    int_en_q <= 1'b0;
      else if (ei_i) int_en_q <= 1'b1;
      if (accept) begin
        pc_q <= pc_i;
        sp_q <= sp_i;
      end
      if (take_trap) vec_q <= AW'(TRAP_VEC);
      if (done_i) begin
        if (state_q == S_ACK && kind_i == OP_RST) vec_q <= rst_vec_i;
        if (state_q == S_ACK_LO) vec_q[DW-1:0]    <= rdata_i;
        if (state_q == S_ACK_HI) vec_q[AW-1 -: DW] <= rdata_i;
      end
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign int_en_o  = int_en_q;
  assign pc_load_o = (state_q == S_LOAD);
  assign sp_load_o = (state_q == S_LOAD);
  assign new_pc_o  = vec_q;
  assign new_sp_o  = sp_m2;
  assign err_o     = err_q;
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter logic [7:0]  CALL_OP  = 8'hCD,
  parameter logic [15:0] TRAP_VEC = 16'h0024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          intr_i,
  input  logic          trap_i,
  input  logic          ei_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  output logic          req_o,
  output logic [2:0]    req_status_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          int_en_o,
  output logic          pc_load_o,
  output logic [AW-1:0] new_pc_o,
  output logic          sp_load_o,
  output logic [AW-1:0] new_sp_o,
  output logic          err_o
);
  op_kind_e      kind;
  logic [AW-1:0] rst_vec;

  iack_decode #(.DW(DW), .AW(AW), .CALL_OP(CALL_OP)) u_decode (
    .op_i      (rdata_i),
    .kind_o    (kind),
    .rst_vec_o (rst_vec)
  );

  iack_ctrl #(.DW(DW), .AW(AW), .TRAP_VEC(TRAP_VEC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .intr_i       (intr_i),
    .trap_i       (trap_i),
    .ei_i         (ei_i),
    .pc_i         (pc_i),
    .sp_i         (sp_i),
    .done_i       (done_i),
    .rdata_i      (rdata_i),
    .kind_i       (kind),
    .rst_vec_i    (rst_vec),
    .req_o        (req_o),
    .req_status_o (req_status_o),
    .req_addr_o   (req_addr_o),
    .req_wdata_o  (req_wdata_o),
    .busy_o       (busy_o),
    .int_en_o     (int_en_o),
    .pc_load_o    (pc_load_o),
    .new_pc_o     (new_pc_o),
    .sp_load_o    (sp_load_o),
    .new_sp_o     (new_sp_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/iack_seq_chk.sv
module iack_seq_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ei_i,
  input logic [AW-1:0] sp_i,
  input logic          req_o,
  input logic [2:0]    req_status_o,
  input logic [AW-1:0] req_addr_o,
  input logic [DW-1:0] req_wdata_o,
  input logic          done_i,
  input logic          busy_o,
  input logic          int_en_o,
  input logic          pc_load_o,
  input logic          sp_load_o,
  input logic [AW-1:0] new_sp_o,
  input logic          err_o
);
  logic [AW-1:0] sp_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_seen <= '0;
    else if (!busy_o) sp_seen <= sp_i;
  end

  AST_MASK_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !int_en_o); // R2

  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_status_o == 3'b111 || req_status_o == 3'b001 || req_status_o == 3'b000)); // R3

  AST_PUSH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_status_o == 3'b001) |->
      (req_addr_o == sp_seen - AW'(1) || req_addr_o == sp_seen - AW'(2))); // R6

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o); // R7

  AST_LOAD_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (sp_load_o && new_sp_o == sp_seen - AW'(2))); // R7

  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !pc_load_o && !req_o)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=>
      (req_o && $stable(req_status_o) && $stable(req_addr_o) && $stable(req_wdata_o))); // R11

  AST_EI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !busy_o && !$rose(busy_o)) |=> (int_en_o || busy_o)); // R2
endmodule

bind iack_seq iack_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ei_i         (ei_i),
  .sp_i         (sp_i),
  .req_o        (req_o),
  .req_status_o (req_status_o),
  .req_addr_o   (req_addr_o),
  .req_wdata_o  (req_wdata_o),
  .done_i       (done_i),
  .busy_o       (busy_o),
  .int_en_o     (int_en_o),
  .pc_load_o    (pc_load_o),
  .sp_load_o    (sp_load_o),
  .new_sp_o     (new_sp_o),
  .err_o        (err_o)
);

// File: tb/sim_iack_seq.sv
`timescale 1ns/1ps
module sim_iack_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        intr_i = 1'b0, trap_i = 1'b0, ei_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic        req_o;
  logic [2:0]  req_status_o;
  logic [15:0] req_addr_o;
  logic [7:0]  req_wdata_o;
  logic        done_i = 1'b0;
  logic [7:0]  rdata_i = '0;
  logic        busy_o, int_en_o, pc_load_o, sp_load_o, err_o;
  logic [15:0] new_pc_o, new_sp_o;

  always #5 clk = ~clk;

  iack_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .intr_i(intr_i), .trap_i(trap_i), .ei_i(ei_i),
    .pc_i(pc_i), .sp_i(sp_i), .req_o(req_o), .req_status_o(req_status_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .done_i(done_i),
    .rdata_i(rdata_i), .busy_o(busy_o), .int_en_o(int_en_o),
    .pc_load_o(pc_load_o), .new_pc_o(new_pc_o), .sp_load_o(sp_load_o),
    .new_sp_o(new_sp_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [2:0]  st;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [3:0]  tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_item(input logic [2:0] st, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rd);
    item_t it;
    it.st = st; it.addr = addr; it.wd = wd; it.rd = rd; it.tag = '0;
    exp_q.push_back(it);
  endtask

  // monitor + bus responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && req_o) begin
        item_t it;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected request", {13'd0, req_status_o, req_addr_o}, 32'd0);
          it = '0;
        end else begin
          it = exp_q.pop_front();
          check(req_status_o == it.st, "R3/R6/R8 status", {29'd0, req_status_o}, {29'd0, it.st});
          check(req_addr_o == it.addr, "R3/R6 address", {16'd0, req_addr_o}, {16'd0, it.addr});
          if (it.st == 3'b001)
            check(req_wdata_o == it.wd, "R6 write data", {24'd0, req_wdata_o}, {24'd0, it.wd});
        end
        for (int k = 0; k < lat; k++) @(negedge clk);
        lat = (lat + 1) % 3;
        done_i = 1'b1;
        rdata_i = it.rd;
        @(negedge clk);
        done_i = 1'b0;
      end
    end
  end

  task automatic wait_busy();
    for (int k = 0; k < 20 && !busy_o; k++) @(negedge clk);
  endtask

  task automatic wait_end(output bit got_load, output bit got_err,
                          output logic [15:0] pc_v, output logic [15:0] sp_v);
    got_load = 0; got_err = 0; pc_v = '0; sp_v = '0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pc_load_o) begin
        got_load = 1; pc_v = new_pc_o; sp_v = new_sp_o;
        if (!sp_load_o) check(1'b0, "R7 sp_load", 0, 1);
        break;
      end
      if (err_o) begin got_err = 1; break; end
    end
  endtask

  task automatic run_intr(input logic [15:0] pc, input logic [15:0] sp,
                          input logic [7:0] op, input logic [7:0] lo,
                          input logic [7:0] hi, input bit is_call, input bit is_bad,
                          input logic [15:0] exp_pc, input string req);
    bit gl, ge;
    logic [15:0] pv, sv;
    pc_i = pc; sp_i = sp;
    push_item(3'b111, pc, 8'h00, op);
    if (is_call) begin
      push_item(3'b111, pc, 8'h00, lo);
      push_item(3'b111, pc, 8'h00, hi);
    end
    if (!is_bad) begin
      push_item(3'b001, sp - 16'd1, pc[15:8], 8'h00);
      push_item(3'b001, sp - 16'd2, pc[7:0], 8'h00);
    end
    intr_i = 1'b1;
    wait_busy();
    intr_i = 1'b0;
    check(int_en_o == 1'b0, "R2 enable cleared on entry", {31'd0, int_en_o}, 0);
    wait_end(gl, ge, pv, sv);
    if (is_bad) begin
      check(ge && !gl, "R10 error pulse, no load", {30'd0, gl, ge}, 32'd1);
      @(negedge clk);
      check(!err_o && !busy_o, "R10 single pulse and idle", {30'd0, err_o, busy_o}, 0);
    end else begin
      check(gl, "R7 load strobe", {31'd0, gl}, 1);
      check(pv == exp_pc, req, {16'd0, pv}, {16'd0, exp_pc});
      check(sv == sp - 16'd2, "R7 new SP", {16'd0, sv}, {16'd0, sp - 16'd2});
    end
    check(exp_q.size() == 0, "R6 all requests issued", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic pulse_ei();
    ei_i = 1'b1;
    @(negedge clk);
    ei_i = 1'b0;
    @(negedge clk);
    check(int_en_o == 1'b1, "R2 ei sets enable", {31'd0, int_en_o}, 1);
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit gl, ge;
    logic [15:0] pv, sv;
    repeat (3) @(negedge clk);
    // R1
    check(!req_o && !busy_o && !int_en_o, "R1 reset idle", {29'd0, req_o, busy_o, int_en_o}, 0);
    check(!pc_load_o && !sp_load_o && !err_o, "R1 reset strobes",
          {29'd0, pc_load_o, sp_load_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: masked request ignored
    intr_i = 1'b1;
    repeat (6) @(negedge clk);
    check(!busy_o && !req_o, "R2 masked intr ignored", {30'd0, busy_o, req_o}, 0);
    intr_i = 1'b0;
    @(negedge clk);

    // R4: restart 7
    pulse_ei();
    run_intr(16'h4321, 16'h8000, 8'hFF, 8'h00, 8'h00, 0, 0, 16'h0038, "R4 restart 7 vector");

    // R4/R6: restart 0 with SP wrap
    pulse_ei();
    run_intr(16'hA55A, 16'h0001, 8'hC7, 8'h00, 8'h00, 0, 0, 16'h0000, "R4 restart 0 vector");

    // R4: restart 5
    pulse_ei();
    run_intr(16'h00FF, 16'h2000, 8'hEF, 8'h00, 8'h00, 0, 0, 16'h0028, "R4 restart 5 vector");

    // R5: call
    pulse_ei();
    run_intr(16'h1000, 16'hFF00, 8'hCD, 8'h34, 8'h12, 1, 0, 16'h1234, "R5 call target");

    // R10: unsupported opcodes
    pulse_ei();
    run_intr(16'h2222, 16'h3000, 8'h00, 8'h00, 8'h00, 0, 1, 16'h0000, "R10");
    pulse_ei();
    run_intr(16'h2222, 16'h3000, 8'hC6, 8'h00, 8'h00, 0, 1, 16'h0000, "R10");

    // R8: trap with enable clear
    pc_i = 16'h0BEE; sp_i = 16'h4000;
    push_item(3'b000, 16'h0BEE, 8'h00, 8'h00);
    push_item(3'b001, 16'h3FFF, 8'h0B, 8'h00);
    push_item(3'b001, 16'h3FFE, 8'hEE, 8'h00);
    check(int_en_o == 1'b0, "R8 enable clear before trap", {31'd0, int_en_o}, 0);
    trap_i = 1'b1;
    @(negedge clk);
    trap_i = 1'b0;
    wait_end(gl, ge, pv, sv);
    check(gl && pv == 16'h0024, "R8 trap vector", {16'd0, pv}, 32'h24);
    check(sv == 16'h3FFE, "R8 trap SP", {16'd0, sv}, 32'h3FFE);
    check(exp_q.size() == 0, "R8 trap requests", exp_q.size(), 0);
    exp_q.delete();

    // R9: trap beats simultaneous enabled intr
    pulse_ei();
    pc_i = 16'h7777; sp_i = 16'h5000;
    push_item(3'b000, 16'h7777, 8'h00, 8'h00);
    push_item(3'b001, 16'h4FFF, 8'h77, 8'h00);
    push_item(3'b001, 16'h4FFE, 8'h77, 8'h00);
    trap_i = 1'b1; intr_i = 1'b1;
    @(negedge clk);
    trap_i = 1'b0;
    wait_end(gl, ge, pv, sv);
    check(gl && pv == 16'h0024, "R9 trap wins", {16'd0, pv}, 32'h24);
    repeat (8) @(negedge clk);
    check(!busy_o && !req_o && !int_en_o, "R9 intr masked after trap",
          {29'd0, busy_o, req_o, int_en_o}, 0);
    intr_i = 1'b0;
    check(exp_q.size() == 0, "R9 request count", exp_q.size(), 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule